// File: doc/BRIEF.md
# Bridge Link Status Width and Speed Sync

This block produces the negotiated-width and current-speed fields of a bridge port's link status word. It combines two sources: the port's own maximum width and speed capability, and the width and speed that the device attached below the port reports. The downstream values are first corrected so that the port never claims more than it supports. A downstream value of zero is replaced with the narrowest width (x1) or the slowest speed (2.5 GT/s).

When no device is attached, or the attached device has no express capability, the port copies its own capability values into the two fields. The two fields are held in registers and change only when the update strobe is sampled high. Every other bit of the status word passes straight from the status input to the status output. Link training is handled elsewhere.

Top module: `link_sta_sync`

## Requirements
- R1: While reset is active, and after it until the first update, the speed field (bits 3:0) and the width field (bits 9:4) of `sta_o` read zero.
- R2: An update with `dev_present_i` low loads `cap_wid_i` into the width field and `cap_spd_i` into the speed field. The downstream inputs have no effect in this case.
- R3: An update with `dev_present_i` high and `dev_cap_i` low also loads the two capability values.
- R4: An update from a capable device that reports a width greater than `cap_wid_i` loads `cap_wid_i`. Width codes are the lane count: 1 means x1 and 32 means x32.
- R5: An update from a capable device that reports width 0 loads width 1 (x1).
- R6: An update from a capable device that reports a width from 1 up to `cap_wid_i` loads the reported width unchanged.
- R7: An update from a capable device that reports a speed code greater than `cap_spd_i` loads `cap_spd_i`. Speed codes are 1 = 2.5, 2 = 5, 3 = 8 and 4 = 16 GT/s.
- R8: An update from a capable device that reports speed 0 loads speed code 1 (2.5 GT/s).
- R9: An update from a capable device that reports a speed from 1 up to `cap_spd_i` loads the reported speed unchanged.
- R10: Every bit of `sta_o` outside bits 9:0 equals the same bit of `sta_i` in every cycle. The status input's own bits 9:0 never reach the output.
- R11: With the update strobe low, both fields keep their values whatever the other inputs do. A value loaded at a clock edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Update strobe that loads both fields |
| cap_wid_i | input | 6 | Port maximum link width code |
| cap_spd_i | input | 4 | Port maximum link speed code |
| dev_present_i | input | 1 | A device is attached below the port |
| dev_cap_i | input | 1 | The attached device has an express capability |
| dev_wid_i | input | 6 | Width field reported by the attached device |
| dev_spd_i | input | 4 | Speed field reported by the attached device |
| sta_i | input | 16 | Port link status word from its owning logic |
| sta_o | output | 16 | Link status word with the synced fields merged in |

## Verification
A wrong clamp decision shows up in `sta_o` on the clock edge that samples the strobe. A missing zero substitution or a wrong choice of source shows up the same way. The bench therefore sweeps every reported width against every capability width, and every speed code against every supported speed, and checks each result one cycle after its strobe. A field register that loads without a strobe appears as a change while the strobe is low. A broken bit merge appears in the upper status bits in the same cycle.

// File: rtl/link_sta_pkg.sv
package link_sta_pkg;

   localparam int unsigned STA_W   = 16;
   localparam int unsigned SPD_W   = 4;
   localparam int unsigned WID_W   = 6;
   localparam int unsigned SPD_LSB = 0;
   localparam int unsigned WID_LSB = 4;

   typedef enum logic [3:0] {
      SPD_NONE = 4'd0,
      SPD_2G5  = 4'd1,
      SPD_5G   = 4'd2,
      SPD_8G   = 4'd3,
      SPD_16G  = 4'd4
   } spd_code_e;

   localparam int unsigned WID_X1 = 1;

endpackage

// File: rtl/link_field_fix.sv
module link_field_fix #(
   parameter int unsigned W    = 4,
   parameter int unsigned DFLT = 1
) (
   input  logic [W-1:0] cap_i,
   input  logic [W-1:0] rpt_i,
   input  logic         use_cap_i,
   output logic [W-1:0] val_o
);
   localparam logic [W-1:0] DFLT_V = W'(DFLT);

   if (DFLT == 0 || DFLT >= (1 << W)) begin : g_bad_dflt
      $fatal(1, "link_field_fix: default code does not fit the field");
   end

   logic rpt_zero;
   logic rpt_over;

   assign rpt_zero = (rpt_i == '0);
   assign rpt_over = (rpt_i > cap_i);

   always_comb begin
      if (use_cap_i)     val_o = cap_i;
      else if (rpt_zero) val_o = DFLT_V;
      else if (rpt_over) val_o = cap_i;
      else               val_o = rpt_i;
   end
endmodule

// File: rtl/link_word_merge.sv
module link_word_merge #(
   parameter int unsigned STA_W   = 16,
   parameter int unsigned SPD_W   = 4,
   parameter int unsigned WID_W   = 6,
   parameter int unsigned SPD_LSB = 0,
   parameter int unsigned WID_LSB = 4
) (
   input  logic [STA_W-1:0] sta_i,
   input  logic [SPD_W-1:0] spd_i,
   input  logic [WID_W-1:0] wid_i,
   output logic [STA_W-1:0] sta_o
);
   localparam int unsigned SPD_MSB = SPD_LSB + SPD_W - 1;
   localparam int unsigned WID_MSB = WID_LSB + WID_W - 1;

   if (SPD_MSB >= STA_W || WID_MSB >= STA_W) begin : g_bad_fit
      $fatal(1, "link_word_merge: field lies outside the status word");
   end
   if (!(SPD_MSB < WID_LSB || WID_MSB < SPD_LSB)) begin : g_bad_overlap
      $fatal(1, "link_word_merge: speed and width fields overlap");
   end

   for (genvar b = 0; b < STA_W; b++) begin : g_bit
      if (b >= SPD_LSB && b <= SPD_MSB) begin : g_spd
         assign sta_o[b] = spd_i[b-SPD_LSB];
      end else if (b >= WID_LSB && b <= WID_MSB) begin : g_wid
         assign sta_o[b] = wid_i[b-WID_LSB];
      end else begin : g_pass
         assign sta_o[b] = sta_i[b];
      end
   end
endmodule

// File: rtl/link_sta_sync.sv
module link_sta_sync
   import link_sta_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_i,
   input  logic [WID_W-1:0] cap_wid_i,
   input  logic [SPD_W-1:0] cap_spd_i,
   input  logic             dev_present_i,
   input  logic             dev_cap_i,
   input  logic [WID_W-1:0] dev_wid_i,
   input  logic [SPD_W-1:0] dev_spd_i,
   input  logic [STA_W-1:0] sta_i,
   output logic [STA_W-1:0] sta_o
);
   localparam logic [STA_W-1:0] FIELD_MASK =
      STA_W'(((1 << SPD_W) - 1) << SPD_LSB) | STA_W'(((1 << WID_W) - 1) << WID_LSB);

   logic             use_cap;
   logic [WID_W-1:0] wid_nxt, wid_q;
   logic [SPD_W-1:0] spd_nxt, spd_q;

   assign use_cap = !dev_present_i || !dev_cap_i;

   link_field_fix #(.W(WID_W), .DFLT(WID_X1)) u_wid_fix (
      .cap_i     (cap_wid_i),
      .rpt_i     (dev_wid_i),
      .use_cap_i (use_cap),
      .val_o     (wid_nxt)
   );

   link_field_fix #(.W(SPD_W), .DFLT(int'(SPD_2G5))) u_spd_fix (
      .cap_i     (cap_spd_i),
      .rpt_i     (dev_spd_i),
      .use_cap_i (use_cap),
      .val_o     (spd_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wid_q <= '0;
         spd_q <= '0;
      end else if (upd_i) begin
         wid_q <= wid_nxt;
         spd_q <= spd_nxt;
      end
   end

   link_word_merge #(
      .STA_W(STA_W), .SPD_W(SPD_W), .WID_W(WID_W),
      .SPD_LSB(SPD_LSB), .WID_LSB(WID_LSB)
   ) u_merge (
      .sta_i (sta_i),
      .spd_i (spd_q),
      .wid_i (wid_q),
      .sta_o (sta_o)
   );

   // R11: no strobe, no change
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(sta_o & FIELD_MASK));

   // R2 / R3: capability mirrored when no usable device
   a_r2_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && (!dev_present_i || !dev_cap_i)) |=>
      (sta_o[WID_LSB +: WID_W] == $past(cap_wid_i) &&
       sta_o[SPD_LSB +: SPD_W] == $past(cap_spd_i)));

   a_r4_wid_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && dev_present_i && dev_cap_i && dev_wid_i > cap_wid_i) |=>
      sta_o[WID_LSB +: WID_W] == $past(cap_wid_i));

   a_r5_wid_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && dev_present_i && dev_cap_i && dev_wid_i == '0) |=>
      sta_o[WID_LSB +: WID_W] == WID_W'(WID_X1));

   a_r7_spd_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && dev_present_i && dev_cap_i && dev_spd_i > cap_spd_i) |=>
      sta_o[SPD_LSB +: SPD_W] == $past(cap_spd_i));

   a_r8_spd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && dev_present_i && dev_cap_i && dev_spd_i == '0) |=>
      sta_o[SPD_LSB +: SPD_W] == SPD_2G5);

   a_r10_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (sta_o & ~FIELD_MASK) == (sta_i & ~FIELD_MASK));
endmodule

// File: tb/link_sta_sync_bench.sv
module link_sta_sync_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_i = 1'b0;
   logic [5:0]  cap_wid_i = '0;
   logic [3:0]  cap_spd_i = '0;
   logic        dev_present_i = 1'b0;
   logic        dev_cap_i = 1'b0;
   logic [5:0]  dev_wid_i = '0;
   logic [3:0]  dev_spd_i = '0;
   logic [15:0] sta_i = '0;
   logic [15:0] sta_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   link_sta_sync u_link_sta_sync (
      .clk(clk), .rst_n(rst_n), .upd_i(upd_i),
      .cap_wid_i(cap_wid_i), .cap_spd_i(cap_spd_i),
      .dev_present_i(dev_present_i), .dev_cap_i(dev_cap_i),
      .dev_wid_i(dev_wid_i), .dev_spd_i(dev_spd_i),
      .sta_i(sta_i), .sta_o(sta_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int fix(input int cap, input int rpt, input bit usecap);
      if (usecap) return cap;
      if (rpt == 0) return 1;
      if (rpt > cap) return cap;
      return rpt;
   endfunction

   function automatic string wreq(input int cap, input int rpt);
      if (rpt == 0) return "R5";
      if (rpt > cap) return "R4";
      return "R6";
   endfunction

   function automatic string sreq(input int cap, input int rpt);
      if (rpt == 0) return "R8";
      if (rpt > cap) return "R7";
      return "R9";
   endfunction

   task automatic apply(input int cw, input int cs, input bit pr, input bit hc,
                        input int dw, input int ds);
      @(negedge clk);
      cap_wid_i = 6'(cw); cap_spd_i = 4'(cs);
      dev_present_i = pr; dev_cap_i = hc;
      dev_wid_i = 6'(dw); dev_spd_i = 4'(ds);
      upd_i = 1'b1;
      @(negedge clk);
      upd_i = 1'b0;
   endtask

   initial begin
      sta_i = 16'hA5FF;
      #5;
      check("R1", int'(sta_o[9:0]), 0);
      check("R10", int'(sta_o[15:10]), int'(sta_i[15:10]));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(sta_o[9:0]), 0);

      // R2: no device, downstream values irrelevant
      apply(8, 3, 1'b0, 1'b1, 63, 15);
      check("R2", int'(sta_o[9:4]), 8);
      check("R2", int'(sta_o[3:0]), 3);
      apply(32, 4, 1'b0, 1'b0, 0, 0);
      check("R2", int'(sta_o[9:4]), 32);
      check("R2", int'(sta_o[3:0]), 4);
      // R3: device without capability
      apply(4, 2, 1'b1, 1'b0, 2, 1);
      check("R3", int'(sta_o[9:4]), 4);
      check("R3", int'(sta_o[3:0]), 2);

      // Width sweep: R4, R5, R6
      for (int cw = 1; cw <= 32; cw++) begin
         for (int dw = 0; dw < 64; dw++) begin
            apply(cw, 4, 1'b1, 1'b1, dw, 2);
            check(wreq(cw, dw), int'(sta_o[9:4]), fix(cw, dw, 1'b0));
         end
      end

      // Speed sweep: R7, R8, R9
      for (int cs = 1; cs <= 4; cs++) begin
         for (int ds = 0; ds < 16; ds++) begin
            apply(16, cs, 1'b1, 1'b1, 3, ds);
            check(sreq(cs, ds), int'(sta_o[3:0]), fix(cs, ds, 1'b0));
            check("R6", int'(sta_o[9:4]), 3);
         end
      end

      // R11: hold with strobe low while inputs move
      apply(12, 3, 1'b1, 1'b1, 5, 2);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         cap_wid_i = 6'(i * 7); cap_spd_i = 4'(i);
         dev_present_i = i[0]; dev_cap_i = i[1];
         dev_wid_i = 6'(i * 9); dev_spd_i = 4'(15 - i);
         @(negedge clk);
         check("R11", int'(sta_o[9:4]), 5);
         check("R11", int'(sta_o[3:0]), 2);
      end

      // R10: upper bits pass through; input's low bits never leak
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         sta_i = 16'(i * 16'h1357 + 16'h0C3F);
         #1;
         check("R10", int'(sta_o[15:10]), int'(sta_i[15:10]));
         check("R10", int'(sta_o[9:0]), (5 << 4) | 2);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule